// File: doc/BRIEF.md
# Tagged Memory Word Checker

A small synchronous memory in which every word carries a 24-bit payload and a 3-bit type tag beside it. A separate 3-bit reference tag register sits next to the memory. Each access can ask for the tag already stored at the addressed word to be tested against that reference tag. The test can require the two tags to be equal or require them to differ. The hardware gives the tag no meaning and never derives it from the data. Software writes every tag value explicitly, both in the words and in the reference register.

When a requested test fails, a sticky pending flag is set and the access still completes. A read still returns its word and a write still stores its word. The interrupt output is the pending flag gated by a mask bit, so software can hold off the trap and deal with it later. A clear input drops the pending flag.

Accesses use a valid/ready request channel. Every accepted access produces exactly one response on a valid/ready response channel. That response carries the stored word as it was before the access, and the result of the tag test. The response stage holds one item. A request is accepted only when that stage is empty or is being emptied in the same cycle, so `req_ready` falls while a response is stalled. A stalled response holds all of its fields steady until `rsp_ready` is high.

Top module: `tag_word_checker`

## Requirements
- R1: After reset `ref_tag` is 0, `irq` is low, `rsp_valid` is low and tag-check interrupts are masked. Memory contents are undefined until written.
- R2: An access is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its response appears on `rsp_valid` in the next cycle. A write with `req_write`=1 stores `req_wdata` and `req_wtag` together, and a later read returns both unchanged.
- R3: The response to a write carries the word and tag that were stored before the write. The tag test of a write uses that previous tag.
- R4: `req_mode`=2'b01 makes `rsp_fail` high exactly when the stored tag differs from the reference tag.
- R5: `req_mode`=2'b10 makes `rsp_fail` high exactly when the stored tag equals the reference tag.
- R6: `req_mode`=2'b00 (no test) and 2'b11 (reserved) never raise `rsp_fail`.
- R7: A failed test does not block the access. A failing write still updates the word, and a failing read still returns it.
- R8: A failed test sets the pending flag whether or not interrupts are masked. `irq` equals pending AND NOT mask, and the flag stays set until cleared.
- R9: `irq_clr` clears the pending flag. A failing access accepted in the same cycle as `irq_clr` wins, and the flag stays set.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_data`, `rsp_tag` and `rsp_fail` hold their values.
- R11: A `ref_wr` pulse loads `ref_tag_in` into the reference register. An access accepted in that same cycle is tested against the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 24 | Write payload |
| req_wtag | input | 3 | Write tag |
| req_mode | input | 2 | Tag test: 00 none, 01 require equal, 10 require different, 11 none |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 24 | Stored payload before the access |
| rsp_tag | output | 3 | Stored tag before the access |
| rsp_fail | output | 1 | Requested tag test failed |
| ref_wr | input | 1 | Load reference tag |
| ref_tag_in | input | 3 | New reference tag |
| ref_tag | output | 3 | Current reference tag |
| mask_wr | input | 1 | Load interrupt mask |
| mask_in | input | 1 | New mask value, 1 = masked |
| irq_clr | input | 1 | Clear pending flag |
| irq | output | 1 | Tag-check interrupt request |

## Verification
A wrong stored tag shows up on the very next response to that word. It appears as a wrong `rsp_tag`, and as a wrong `rsp_fail` whenever that access asks for a test. A lost or spurious pending flag stays invisible while interrupts are masked. It surfaces on `irq` in the cycle after the mask is lifted, so the bench always fails a test under mask and then unmasks. A stale or early reference tag can only be seen on an access that lands in the cycle of a `ref_wr`, so that same-cycle case is driven on purpose.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  typedef enum logic [1:0] {
    CHK_NONE   = 2'b00,
    CHK_SAME   = 2'b01,
    CHK_DIFFER = 2'b10,
    CHK_RSVD   = 2'b11
  } chk_mode_e;
endpackage

// File: rtl/tagchk_store.sv
module tagchk_store #(
  parameter int DATA_W = 24,
  parameter int TAG_W  = 3,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TAG_W-1:0]  wtag,
  output logic [DATA_W-1:0] rdata,
  output logic [TAG_W-1:0]  rtag
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= {wtag, wdata};
  end

  assign {rtag, rdata} = cells[addr];
endmodule

// File: rtl/tagchk_compare.sv
module tagchk_compare
  import tagchk_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic [1:0]       mode,
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] ref_val,
  output logic             fail
);
  always_comb begin
    case (chk_mode_e'(mode))
      CHK_SAME:   fail = (stored != ref_val);
      CHK_DIFFER: fail = (stored == ref_val);
      default:    fail = 1'b0;
    endcase
  end
endmodule

// File: rtl/tagchk_ctrl.sv
module tagchk_ctrl #(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_wr,
  input  logic [TAG_W-1:0] ref_in,
  input  logic             mask_wr,
  input  logic             mask_in,
  input  logic             clr,
  input  logic             set_fail,
  output logic [TAG_W-1:0] ref_q,
  output logic             mask_q,
  output logic             pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      mask_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (ref_wr)  ref_q  <= ref_in;
      if (mask_wr) mask_q <= mask_in;
      if (set_fail)  pend_q <= 1'b1;
      else if (clr)  pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_word_checker.sv
module tag_word_checker #(
  parameter int DATA_W = 24,
  parameter int TAG_W  = 3,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_wtag,
  input  logic [1:0]        req_mode,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_fail,
  input  logic              ref_wr,
  input  logic [TAG_W-1:0]  ref_tag_in,
  output logic [TAG_W-1:0]  ref_tag,
  input  logic              mask_wr,
  input  logic              mask_in,
  input  logic              irq_clr,
  output logic              irq
);
  logic              accept;
  logic [DATA_W-1:0] cur_data;
  logic [TAG_W-1:0]  cur_tag;
  logic              cur_fail;
  logic              irq_mask;
  logic              irq_pend;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [TAG_W-1:0]  rsp_tag_q;
  logic              rsp_fail_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  tagchk_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .wr_en (accept && req_write),
    .addr  (req_addr),
    .wdata (req_wdata),
    .wtag  (req_wtag),
    .rdata (cur_data),
    .rtag  (cur_tag)
  );

  tagchk_compare #(.TAG_W(TAG_W)) u_cmp (
    .mode    (req_mode),
    .stored  (cur_tag),
    .ref_val (ref_tag),
    .fail    (cur_fail)
  );

  tagchk_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_wr   (ref_wr),
    .ref_in   (ref_tag_in),
    .mask_wr  (mask_wr),
    .mask_in  (mask_in),
    .clr      (irq_clr),
    .set_fail (accept && cur_fail),
    .ref_q    (ref_tag),
    .mask_q   (irq_mask),
    .pend_q   (irq_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_tag_q   <= '0;
      rsp_fail_q  <= 1'b0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= cur_data;
      rsp_tag_q   <= cur_tag;
      rsp_fail_q  <= cur_fail;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_tag   = rsp_tag_q;
  assign rsp_fail  = rsp_fail_q;
  assign irq       = irq_pend && !irq_mask;
endmodule

// File: rtl/tagchk_sva.sv
module tagchk_sva #(
  parameter int DATA_W = 24,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_mode,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic              rsp_fail,
  input logic              irq_clr,
  input logic              irq,
  input logic              pend
);
  logic acc_q;
  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= req_valid && req_ready;
  end

  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R2

  AST_NO_TEST_NO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_mode == 2'b00 || req_mode == 2'b11) |=> !rsp_fail); // R6

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_tag) && $stable(rsp_fail)); // R10

  AST_FAIL_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && rsp_fail |-> pend); // R8

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq || (acc_q && rsp_fail)); // R9
endmodule

bind tag_word_checker tagchk_sva #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mode  (req_mode),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_tag   (rsp_tag),
  .rsp_fail  (rsp_fail),
  .irq_clr   (irq_clr),
  .irq       (irq),
  .pend      (irq_pend)
);

// File: tb/test_tag_word_checker.sv
module test_tag_word_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic [2:0]  req_wtag = '0;
  logic [1:0]  req_mode = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [23:0] rsp_data;
  logic [2:0]  rsp_tag;
  logic        rsp_fail;
  logic        ref_wr = 1'b0;
  logic [2:0]  ref_tag_in = '0;
  logic [2:0]  ref_tag;
  logic        mask_wr = 1'b0;
  logic        mask_in = 1'b0;
  logic        irq_clr = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          known;
    logic [23:0] d;
    logic [2:0]  t;
    bit          f;
    string       rq;
  } exp_t;
  exp_t sb[$];

  logic [23:0] m_data [16];
  logic [2:0]  m_tag  [16];
  bit          m_known [16];
  logic [2:0]  ref_m = '0;

  always #10 clk = ~clk;

  tag_word_checker i_tag_word_checker (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic acc(input bit w, input logic [3:0] a, input logic [23:0] d,
                     input logic [2:0] t, input logic [1:0] mode, input string rq);
    exp_t e;
    e.known = m_known[a];
    e.d = m_data[a];
    e.t = m_tag[a];
    e.f = (mode == 2'b01) ? (m_tag[a] != ref_m) :
          (mode == 2'b10) ? (m_tag[a] == ref_m) : 1'b0;
    e.rq = rq;
    sb.push_back(e);
    if (w) begin m_data[a] = d; m_tag[a] = t; m_known[a] = 1'b1; end
    req_valid = 1'b1; req_write = w; req_addr = a;
    req_wdata = d; req_wtag = t; req_mode = mode;
    step();
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_mask(input bit v);
    mask_wr = 1'b1; mask_in = v; step(); mask_wr = 1'b0;
  endtask

  task automatic set_ref(input logic [2:0] v);
    ref_wr = 1'b1; ref_tag_in = v; step(); ref_wr = 1'b0; ref_m = v;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", 32'(rsp_valid), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_fail == e.f, e.rq, "rsp_fail", 32'(rsp_fail), 32'(e.f));
        if (e.known) begin
          chk(rsp_data == e.d, e.rq, "rsp_data", 32'(rsp_data), 32'(e.d));
          chk(rsp_tag == e.t, e.rq, "rsp_tag", 32'(rsp_tag), 32'(e.t));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] held_d;
    logic [2:0]  held_t;
    for (int i = 0; i < 16; i++) begin
      m_known[i] = 1'b0; m_data[i] = '0; m_tag[i] = '0;
    end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(ref_tag == 3'd0, "R1", "ref_tag after reset", 32'(ref_tag), 32'd0);
    chk(!irq, "R1", "irq after reset", 32'(irq), 32'd0);
    chk(!rsp_valid, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

    // R2 writes then reads, no test
    acc(1'b1, 4'd0, 24'h123456, 3'd5, 2'b00, "R2");
    acc(1'b1, 4'd1, 24'hABCDEF, 3'd2, 2'b00, "R2");
    acc(1'b1, 4'd2, 24'h000001, 3'd7, 2'b00, "R2");
    acc(1'b1, 4'd15, 24'hFFFFFF, 3'd0, 2'b00, "R2");
    acc(1'b0, 4'd0, 24'h0, 3'd0, 2'b00, "R2");
    acc(1'b0, 4'd1, 24'h0, 3'd0, 2'b00, "R2");
    acc(1'b0, 4'd2, 24'h0, 3'd0, 2'b11, "R6");
    acc(1'b0, 4'd15, 24'h0, 3'd0, 2'b00, "R2");
    step();

    // R4 equal-test with ref 5, still masked
    set_ref(3'd5);
    chk(ref_tag == 3'd5, "R11", "ref_tag loaded", 32'(ref_tag), 32'd5);
    acc(1'b0, 4'd0, 24'h0, 3'd0, 2'b01, "R4");
    chk(!irq, "R8", "irq after passing test", 32'(irq), 32'd0);
    acc(1'b0, 4'd1, 24'h0, 3'd0, 2'b01, "R4");
    step();
    chk(!irq, "R8", "irq while masked", 32'(irq), 32'd0);
    set_mask(1'b0);
    chk(irq, "R8", "irq after unmask (sticky)", 32'(irq), 32'd1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    chk(!irq, "R9", "irq after clear", 32'(irq), 32'd0);

    // R5 unequal-test, R6 reserved mode
    acc(1'b0, 4'd1, 24'h0, 3'd0, 2'b10, "R5");
    acc(1'b0, 4'd2, 24'h0, 3'd0, 2'b11, "R6");
    acc(1'b0, 4'd1, 24'h0, 3'd0, 2'b00, "R6");
    step();
    chk(!irq, "R5", "irq after passing unequal test", 32'(irq), 32'd0);
    acc(1'b0, 4'd0, 24'h0, 3'd0, 2'b10, "R5");
    step();
    chk(irq, "R5", "irq after failing unequal test", 32'(irq), 32'd1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;

    // R3/R7 failing write uses old tag and still writes
    acc(1'b1, 4'd1, 24'h55AA55, 3'd5, 2'b01, "R3");
    acc(1'b0, 4'd1, 24'h0, 3'd0, 2'b01, "R7");
    step();
    chk(irq, "R7", "irq after failing write", 32'(irq), 32'd1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    chk(!irq, "R9", "irq cleared", 32'(irq), 32'd0);

    // R9 clear and failing access in same cycle
    irq_clr = 1'b1;
    acc(1'b0, 4'd2, 24'h0, 3'd0, 2'b01, "R9");
    irq_clr = 1'b0;
    chk(irq, "R9", "fail wins over clear", 32'(irq), 32'd1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;

    // R11 ref write in same cycle as access uses old ref (5)
    ref_wr = 1'b1; ref_tag_in = 3'd2;
    acc(1'b0, 4'd0, 24'h0, 3'd0, 2'b01, "R11");
    ref_wr = 1'b0; ref_m = 3'd2;
    chk(!irq, "R11", "old ref used in write cycle", 32'(irq), 32'd0);
    acc(1'b0, 4'd0, 24'h0, 3'd0, 2'b01, "R11");
    chk(irq, "R11", "new ref used afterwards", 32'(irq), 32'd1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;

    // R10 back-pressure
    step();
    rsp_ready = 1'b0;
    acc(1'b0, 4'd15, 24'h0, 3'd0, 2'b00, "R10");
    @(negedge clk);
    chk(rsp_valid, "R10", "rsp_valid during stall", 32'(rsp_valid), 32'd1);
    chk(!req_ready, "R10", "req_ready during stall", 32'(req_ready), 32'd0);
    held_d = rsp_data; held_t = rsp_tag;
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_data == held_d && rsp_tag == held_t, "R10", "held response",
        32'(rsp_data), 32'(held_d));
    chk(rsp_data == 24'hFFFFFF, "R10", "stalled data", 32'(rsp_data), 32'hFFFFFF);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    step(); step();
    chk(!rsp_valid, "R10", "response drained", 32'(rsp_valid), 32'd0);

    // R8 re-mask hides a pending request
    acc(1'b0, 4'd2, 24'h0, 3'd0, 2'b01, "R8");
    set_mask(1'b1);
    chk(!irq, "R8", "irq masked again", 32'(irq), 32'd0);
    set_mask(1'b0);
    chk(irq, "R8", "pending kept under mask", 32'(irq), 32'd1);
    step(); step();
    chk(sb.size() == 0, "R2", "all responses seen", 32'(sb.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule